// File: doc/BRIEF.md
# Multiplier-free 8-point forward DCT

This block computes a one-dimensional 8-point forward discrete cosine transform on groups of eight signed samples. The datapath has no multipliers. Each cosine weight is scaled by 256, rounded to an integer that is a short sum or difference of powers of two, and applied as a chain of shifted additions and subtractions. A group of samples is taken through a valid/ready handshake. After a fixed three-stage pipeline the block presents one DC term, clamped to a small unsigned range, and seven AC terms in sign-magnitude form.

The flow graph is the usual fast one. Mirrored samples are first summed and differenced. The sums feed a small even network (terms 0, 2, 4, 6). The differences feed four odd dot products (terms 1, 3, 5, 7). Every product stays at full precision until a single round-to-nearest step at the output.

A stalled output freezes the entire pipeline and drops the input ready signal, so back-pressure costs no extra storage. In a first pass the samples are 8-bit unsigned pixels, carried on a 9-bit two's-complement input.

Top module: `mfdct8`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: Sample n is `inSamples[9n+8:9n]`, in two's complement. For k = 1..7 the raw term is V_k = Σ_n x_n·Q((2n+1)k). Q(m) is 256·cos(mπ/16) reduced to the first quadrant with its sign, using the magnitudes 251, 237, 213, 181, 142, 98 and 50 for m = 1..7 (and 0 for m = 8). The DC raw term is V_0 = 181·Σ x_n. Each term rounds to r_k = floor((V_k + 512) / 1024).
- R3: `outDc` equals r_0 clamped to the range 0..511.
- R4: AC term k (k = 1..7) appears on `outAcMag[8k-1:8k-8]` and `outAcSign[k-1]`. The sign bit is 1 exactly when r_k < 0, so a zero result always carries sign 0. The magnitude is |r_k| saturated to 255.
- R5: A group is accepted on a rising edge where `inValid` and `inReady` are both 1. If `outReady` stays high, its result is shown with `outValid` = 1 right after the third rising edge, counting the accepting edge as the first. Groups offered on consecutive cycles come out on consecutive cycles.
- R6: While `outValid` = 1 and `outReady` = 0, `outValid` and every output field stay unchanged across the next edge.
- R7: `inReady` is 1 exactly when `outValid` = 0 or `outReady` = 1. A group presented while `inReady` = 0 is not taken and produces no result.
- R8: Each accepted group yields exactly one result, and results leave in the order their groups were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A group of eight samples is offered |
| inReady | output | 1 | The block can take a group on this edge |
| inSamples | input | 72 | Eight 9-bit two's-complement samples; sample n at bits 9n+8..9n |
| outValid | output | 1 | A result is presented |
| outReady | input | 1 | The consumer takes the result on this edge |
| outDc | output | 9 | Clamped unsigned DC term |
| outAcMag | output | 56 | Seven saturated AC magnitudes; term k at bits 8k-1..8k-8 |
| outAcSign | output | 7 | AC sign bits; term k at bit k-1 |

## Verification
A result becomes visible half a cycle after the third rising edge that follows acceptance, with the accepting edge counted as the first. The bench samples every port on the falling edge. When it sees an acceptance it pushes the expected result from its own cosine model, stamped with the current falling-edge count plus three. In phases where `outReady` never drops, each result must appear at exactly its stamped count. In the back-pressure phase the bench relaxes this to order and content. On every cycle of that phase it also checks that a stalled result holds and that `inReady` stays low while the result waits.

// File: rtl/mfdct8_pkg.sv
package mfdct8_pkg;

  // Load strobes from the control to the three pipeline stages.
  typedef struct packed {
    logic ldFront;  // butterfly registers
    logic ldMid;    // product accumulators
    logic ldBack;   // formatted outputs
  } dctStrobe_t;

  // The weights are pre-scaled by 2**COEF_SHIFT.
  localparam int COEF_SHIFT = 8;

  // Depth of the pipeline, from the accepting edge to a visible result.
  localparam int PIPE_DEPTH = 3;

endpackage

// File: rtl/mfdct8_ctrl.sv
module mfdct8_ctrl
  import mfdct8_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output dctStrobe_t strobe
);

  logic [PIPE_DEPTH-1:0] stageValid;
  logic                  advance;

  // The whole pipeline moves only when the output slot is free or being taken.
  assign advance  = !stageValid[PIPE_DEPTH-1] || outReady;
  assign inReady  = advance;
  assign outValid = stageValid[PIPE_DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= '0;
    end else if (advance) begin
      stageValid <= {stageValid[PIPE_DEPTH-2:0], inValid};
    end
  end

  assign strobe.ldFront = advance && inValid;
  assign strobe.ldMid   = advance && stageValid[0];
  assign strobe.ldBack  = advance && stageValid[1];

endmodule

// File: rtl/mfdct8_datapath.sv
module mfdct8_datapath
  import mfdct8_pkg::*;
#(
  parameter int IN_W      = 9,
  parameter int DC_W      = 9,
  parameter int MAG_W     = 8,
  parameter int OUT_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dctStrobe_t         strobe,
  input  logic [8*IN_W-1:0]  inSamples,
  output logic [DC_W-1:0]    dcOut,
  output logic [7*MAG_W-1:0] acMagOut,
  output logic [6:0]         acSignOut
);

  localparam int N_PT  = 8;
  localparam int HALF  = N_PT / 2;
  localparam int ACC_W = IN_W + 12;
  localparam int EXT_W = ACC_W - IN_W;
  localparam int FRAC  = COEF_SHIFT + OUT_SHIFT;

  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t ROUND_BIAS = acc_t'(2 ** (FRAC - 1));
  localparam acc_t DC_LIM     = acc_t'(2 ** DC_W - 1);
  localparam acc_t MAG_LIM    = acc_t'(2 ** MAG_W - 1);

  // Codes for the shift-add weights.
  localparam int K251 = 0;
  localparam int K213 = 1;
  localparam int K142 = 2;
  localparam int K50  = 3;
  localparam int K181 = 4;
  localparam int K237 = 5;
  localparam int K98  = 6;

  // Odd rows (terms 1,3,5,7): which weight each difference takes, and its sign.
  localparam int ODD_SEL [HALF][HALF] = '{
    '{K251, K213, K142, K50 },
    '{K213, K50,  K251, K142},
    '{K142, K251, K50,  K213},
    '{K50,  K142, K213, K251}
  };
  localparam bit ODD_NEG [HALF][HALF] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1}
  };

  // Weights times 256, formed only from shifted adds and subtracts.
  function automatic acc_t scaleBy(input int sel, input acc_t x);
    case (sel)
      K251:    return (x <<< 8) - (x <<< 2) - x;
      K213:    return (x <<< 8) - (x <<< 5) - (x <<< 3) - (x <<< 2) + x;
      K142:    return (x <<< 8) - (x <<< 6) - (x <<< 5) - (x <<< 4) - (x <<< 1);
      K50:     return (x <<< 6) - (x <<< 3) - (x <<< 2) - (x <<< 1);
      K181:    return (x <<< 7) + (x <<< 5) + (x <<< 4) + (x <<< 2) + x;
      K237:    return (x <<< 8) - (x <<< 4) - (x <<< 1) - x;
      K98:     return (x <<< 6) + (x <<< 5) + (x <<< 1);
      default: return '0;
    endcase
  endfunction

  // ---------------- stage 1: mirrored butterflies ----------------
  acc_t xExt  [N_PT];
  acc_t sPair [HALF];
  acc_t dNext [HALF];
  acc_t eNext [HALF];
  acc_t eReg  [HALF];
  acc_t dReg  [HALF];

  generate
    for (genvar i = 0; i < N_PT; i++) begin : g_ext
      assign xExt[i] = {{EXT_W{inSamples[i*IN_W+IN_W-1]}}, inSamples[i*IN_W +: IN_W]};
    end
    for (genvar i = 0; i < HALF; i++) begin : g_fly
      assign sPair[i] = xExt[i] + xExt[N_PT-1-i];
      assign dNext[i] = xExt[i] - xExt[N_PT-1-i];
    end
  endgenerate

  assign eNext[0] = sPair[0] + sPair[3];
  assign eNext[1] = sPair[1] + sPair[2];
  assign eNext[2] = sPair[1] - sPair[2];
  assign eNext[3] = sPair[0] - sPair[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HALF; i++) begin
        eReg[i] <= '0;
        dReg[i] <= '0;
      end
    end else if (strobe.ldFront) begin
      eReg <= eNext;
      dReg <= dNext;
    end
  end

  // ---------------- stage 2: weighted sums ----------------
  acc_t accNext [N_PT];
  acc_t accReg  [N_PT];

  always_comb begin
    accNext[0] = scaleBy(K181, eReg[0] + eReg[1]);
    accNext[4] = scaleBy(K181, eReg[0] - eReg[1]);
    accNext[2] = scaleBy(K237, eReg[3]) + scaleBy(K98, eReg[2]);
    accNext[6] = scaleBy(K98, eReg[3]) - scaleBy(K237, eReg[2]);
    for (int r = 0; r < HALF; r++) begin
      accNext[2*r+1] = '0;
      for (int n = 0; n < HALF; n++) begin
        if (ODD_NEG[r][n]) accNext[2*r+1] = accNext[2*r+1] - scaleBy(ODD_SEL[r][n], dReg[n]);
        else               accNext[2*r+1] = accNext[2*r+1] + scaleBy(ODD_SEL[r][n], dReg[n]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < N_PT; k++) accReg[k] <= '0;
    end else if (strobe.ldMid) begin
      accReg <= accNext;
    end
  end

  // ---------------- stage 3: round, clamp, sign-magnitude ----------------
  logic [DC_W-1:0]    dcNext;
  logic [7*MAG_W-1:0] magNext;
  logic [6:0]         signNext;

  generate
    for (genvar k = 0; k < N_PT; k++) begin : g_fmt
      acc_t rounded;
      assign rounded = (accReg[k] + ROUND_BIAS) >>> FRAC;
      if (k == 0) begin : g_dc
        always_comb begin
          if (rounded < 0)           dcNext = '0;
          else if (rounded > DC_LIM) dcNext = DC_LIM[DC_W-1:0];
          else                       dcNext = rounded[DC_W-1:0];
        end
      end else begin : g_ac
        acc_t             absVal;
        logic [MAG_W-1:0] magK;
        assign absVal = (rounded < 0) ? -rounded : rounded;
        assign magK   = (absVal > MAG_LIM) ? MAG_LIM[MAG_W-1:0] : absVal[MAG_W-1:0];
        assign magNext[(k-1)*MAG_W +: MAG_W] = magK;
        assign signNext[k-1] = rounded < 0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dcOut     <= '0;
      acMagOut  <= '0;
      acSignOut <= '0;
    end else if (strobe.ldBack) begin
      dcOut     <= dcNext;
      acMagOut  <= magNext;
      acSignOut <= signNext;
    end
  end

endmodule

// File: rtl/mfdct8.sv
module mfdct8
  import mfdct8_pkg::*;
#(
  parameter int IN_W      = 9,
  parameter int DC_W      = 9,
  parameter int MAG_W     = 8,
  parameter int OUT_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [8*IN_W-1:0]  inSamples,
  output logic               outValid,
  input  logic               outReady,
  output logic [DC_W-1:0]    outDc,
  output logic [7*MAG_W-1:0] outAcMag,
  output logic [6:0]         outAcSign
);

  dctStrobe_t strobe;

  mfdct8_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  mfdct8_datapath #(
    .IN_W      (IN_W),
    .DC_W      (DC_W),
    .MAG_W     (MAG_W),
    .OUT_SHIFT (OUT_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inSamples (inSamples),
    .dcOut     (outDc),
    .acMagOut  (outAcMag),
    .acSignOut (outAcSign)
  );

endmodule

// File: rtl/mfdct8_chk.sv
module mfdct8_chk #(
  parameter int DC_W  = 9,
  parameter int MAG_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic               outValid,
  input logic               outReady,
  input logic [DC_W-1:0]    outDc,
  input logic [7*MAG_W-1:0] outAcMag,
  input logic [6:0]         outAcSign
);

  logic [6:0] magNonZero;

  generate
    for (genvar k = 0; k < 7; k++) begin : g_nz
      assign magNonZero[k] = |outAcMag[k*MAG_W +: MAG_W];
    end
  endgenerate

  // R4: a zero magnitude never carries a negative sign
  assert_zero_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outAcSign & ~magNonZero) == 7'd0));

  // R5: three edges from acceptance to a visible result when nothing stalls
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) ##1 outReady ##1 outReady |=> outValid);

  // R6: a result that is not taken holds still
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outDc) && $stable(outAcMag) && $stable(outAcSign)));

  // R7: no intake while the output is stalled
  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R7: an empty output slot always admits a group
  assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

endmodule

bind mfdct8 mfdct8_chk #(.DC_W(DC_W), .MAG_W(MAG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .outDc     (outDc),
  .outAcMag  (outAcMag),
  .outAcSign (outAcSign)
);

// File: tb/sim_mfdct8.sv
module sim_mfdct8;

  localparam int IN_W  = 9;
  localparam int DC_W  = 9;
  localparam int MAG_W = 8;
  localparam int EW    = DC_W + 7*MAG_W + 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic               inValid = 1'b0;
  logic               inReady;
  logic [8*IN_W-1:0]  inSamples = '0;
  logic               outValid;
  logic               outReady = 1'b0;
  logic [DC_W-1:0]    outDc;
  logic [7*MAG_W-1:0] outAcMag;
  logic [6:0]         outAcSign;

  mfdct8 #(.IN_W(IN_W), .DC_W(DC_W), .MAG_W(MAG_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSamples(inSamples), .outValid(outValid), .outReady(outReady),
    .outDc(outDc), .outAcMag(outAcMag), .outAcSign(outAcSign)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit strict = 1'b0;
  bit done = 1'b0;
  bit prevStall = 1'b0;
  logic [EW-1:0] heldOut;
  logic [EW-1:0] qExp[$];
  int qDue[$];
  int unsigned rng = 32'h1234_5678;

  function automatic int cosMag(int j);
    case (j)
      0: return 256; 1: return 251; 2: return 237; 3: return 213;
      4: return 181; 5: return 142; 6: return 98;  7: return 50;
      default: return 0;
    endcase
  endfunction

  // 256*cos(m*pi/16), first-quadrant magnitude with sign
  function automatic int cosQ(int m);
    int j;
    j = m % 32;
    if (j > 16) j = 32 - j;
    if (j <= 8) return cosMag(j);
    return -cosMag(16 - j);
  endfunction

  function automatic logic [EW-1:0] refModel(logic [8*IN_W-1:0] smp);
    int x[8];
    int v, r, a;
    logic [DC_W-1:0]    dc;
    logic [7*MAG_W-1:0] mg;
    logic [6:0]         sg;
    for (int n = 0; n < 8; n++) x[n] = int'($signed(smp[n*IN_W +: IN_W]));
    dc = '0; mg = '0; sg = '0;
    for (int k = 0; k < 8; k++) begin
      v = 0;
      for (int n = 0; n < 8; n++) v += (k == 0) ? 181 * x[n] : x[n] * cosQ((2*n+1)*k);
      r = (v + 512) >>> 10;
      if (k == 0) begin
        if (r < 0) r = 0;
        if (r > (1 << DC_W) - 1) r = (1 << DC_W) - 1;
        dc = DC_W'(r);
      end else begin
        sg[k-1] = (r < 0);
        a = (r < 0) ? -r : r;
        if (a > (1 << MAG_W) - 1) a = (1 << MAG_W) - 1;
        mg[(k-1)*MAG_W +: MAG_W] = MAG_W'(a);
      end
    end
    return {dc, mg, sg};
  endfunction

  function automatic logic [8*IN_W-1:0] pk(input int v [8]);
    logic [8*IN_W-1:0] p;
    for (int n = 0; n < 8; n++) p[n*IN_W +: IN_W] = IN_W'(v[n]);
    return p;
  endfunction

  function automatic int unsigned nextRand(int unsigned s);
    int unsigned t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // Monitor and reference model, sampled on the falling edge
  always @(negedge clk) begin
    logic [EW-1:0] exp;
    logic [EW-1:0] act;
    int due;
    if (rstN && !done) begin
      cyc++;
      act = {outDc, outAcMag, outAcSign};
      if (prevStall) begin
        checks++;
        if (!outValid || act !== heldOut) begin
          errors++;
          $display("FAIL R6 held result changed: actual %h expected %h", act, heldOut);
        end
      end
      if (outValid && !outReady) begin
        checks++;
        if (inReady !== 1'b0) begin
          errors++;
          $display("FAIL R7 inReady during stall: actual %b expected 0", inReady);
        end
      end
      if (outValid && outReady) begin
        if (qExp.size() == 0) begin
          checks++; errors++;  // R7/R8: a result with no accepted group
          $display("FAIL R8 unexpected result: actual %h expected none", act);
        end else begin
          exp = qExp.pop_front();
          due = qDue.pop_front();
          checks++;
          if (act[EW-1 -: DC_W] !== exp[EW-1 -: DC_W]) begin
            errors++;
            $display("FAIL R3 (R2) DC: actual %0d expected %0d", act[EW-1 -: DC_W], exp[EW-1 -: DC_W]);
          end
          checks++;
          if (act[7 +: 7*MAG_W] !== exp[7 +: 7*MAG_W]) begin
            errors++;
            $display("FAIL R4 (R2) AC magnitudes: actual %h expected %h", act[7 +: 7*MAG_W], exp[7 +: 7*MAG_W]);
          end
          checks++;
          if (act[6:0] !== exp[6:0]) begin
            errors++;
            $display("FAIL R4 AC signs: actual %b expected %b", act[6:0], exp[6:0]);
          end
          if (strict) begin
            checks++;
            if (cyc != due) begin
              errors++;
              $display("FAIL R5 result timing: actual cycle %0d expected %0d", cyc, due);
            end
          end
        end
      end else if (strict && qExp.size() > 0 && qDue[0] < cyc) begin
        checks++; errors++;
        $display("FAIL R5 result missing: actual none expected at cycle %0d", qDue[0]);
        void'(qExp.pop_front());
        void'(qDue.pop_front());
      end
      prevStall = outValid && !outReady;
      heldOut = act;
      if (inValid && inReady) begin
        qExp.push_back(refModel(inSamples));
        qDue.push_back(cyc + 3);
      end
    end
  end

  task automatic sendGroup(input logic [8*IN_W-1:0] s);
    bit took;
    took = 1'b0;
    inSamples = s;
    inValid = 1'b1;
    while (!took) begin
      @(negedge clk);
      took = inReady;
      @(posedge clk);
      #5;
    end
  endtask

  task automatic idleAndDrain();
    inValid = 1'b0;
    while (qExp.size() != 0) begin
      @(posedge clk);
      #5;
    end
    repeat (2) @(posedge clk);
    #5;
  endtask

  task automatic randGroup(input bit signedRange);
    int v [8];
    for (int n = 0; n < 8; n++) begin
      rng = nextRand(rng);
      v[n] = signedRange ? int'(rng % 512) - 256 : int'(rng % 256);
    end
    sendGroup(pk(v));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state: actual outValid=%b inReady=%b expected 0 1", outValid, inReady);
    end
    @(posedge clk);
    #5;

    // Back-to-back pixel groups, consumer always ready (R2 R3 R4 R5 R8)
    strict = 1'b1;
    outReady = 1'b1;
    sendGroup(pk('{0, 0, 0, 0, 0, 0, 0, 0}));
    sendGroup(pk('{255, 255, 255, 255, 255, 255, 255, 255}));
    sendGroup(pk('{0, 36, 72, 108, 144, 180, 216, 252}));
    sendGroup(pk('{255, 0, 255, 0, 255, 0, 255, 0}));
    sendGroup(pk('{0, 0, 0, 200, 0, 0, 0, 0}));
    sendGroup(pk('{0, 0, 0, 0, 255, 255, 255, 255}));
    for (int g = 0; g < 16; g++) randGroup(1'b0);
    idleAndDrain();

    // Signed inputs: DC clamp at zero and AC saturation at 255 (R3 R4)
    sendGroup(pk('{255, 255, 255, 255, -256, -256, -256, -256}));
    sendGroup(pk('{-256, -256, -256, -256, 255, 255, 255, 255}));
    sendGroup(pk('{-256, -256, -256, -256, -256, -256, -256, -256}));
    sendGroup(pk('{255, -256, 255, -256, 255, -256, 255, -256}));
    for (int g = 0; g < 8; g++) randGroup(1'b1);
    idleAndDrain();

    // Back-pressure: hold, blocked intake, order (R6 R7 R8)
    strict = 1'b0;
    fork
      begin
        for (int g = 0; g < 14; g++) randGroup(g[0]);
        inValid = 1'b0;
      end
      begin
        logic [63:0] pat;
        pat = 64'hA5C3_96F0_3C5A_0FF1;
        for (int t = 0; t < 96; t++) begin
          @(posedge clk);
          #5 outReady = pat[t % 64];
        end
        outReady = 1'b1;
      end
    join
    idleAndDrain();

    checks++;  // R8: every accepted group produced its result
    if (qExp.size() != 0) begin
      errors++;
      $display("FAIL R8 results outstanding: actual %0d expected 0", qExp.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule